// File: doc/BRIEF.md
# Debug breakpoint request generator

This block turns comparator match strobes into CPU breakpoint requests. A debug run is armed by a strobe. The run then waits for a trigger chosen by a mode field from comparators A, B and C. When the trigger arrives, one breakpoint request is issued and the run is complete. Another request needs a fresh arm.

Two settings decide when the request appears:
- **Timing select.** With end-trigger, the request is raised in the trigger cycle itself. With begin-trigger, the request waits until the trace FIFO occupancy count reaches eight words.
- **Style select.** A forced request is a level. It stays up until the CPU signals an instruction boundary. A tagged request is instead attached to the next opcode that enters a small model of the CPU instruction queue. The break fires only when that tagged entry reaches the head of the queue and executes. A change-of-flow flush discards queued tags.

The controller is a state machine with six states:
- **IDLE:** not armed.
- **ARMED:** waiting for the trigger.
- **FILL:** begin-trigger seen, waiting for the FIFO count.
- **FORCE:** forced request pending.
- **TAGWAIT:** tagged request waiting for a fetch.
- **DONE:** run finished.

Its transitions are:
- **arm:** IDLE or DONE to ARMED.
- **trigger:** ARMED to FILL, FORCE, TAGWAIT or DONE.
- **filled:** FILL to FORCE, TAGWAIT or DONE.
- **consume:** FORCE to DONE on a boundary.
- **attach:** TAGWAIT to DONE on an accepted fetch.
- **disable:** any state to IDLE when debug is off.

A request that is issued and consumed or attached in the same cycle goes straight to DONE.

Top module: `dbg_brk_gen`

## Requirements
- R1: With `dbg_en` low, `force_brk`, `fetch_tag` and `tag_brk` are all 0, and the state returns to IDLE, so a pending request is dropped.
- R2: With `brk_en` low, no request is ever output. A trigger seen while `brk_en` is low ends the run with no break.
- R3: With `begin_sel` = 1, a trigger moves the run to FILL. The request is raised in the first cycle in which `fifo_cnt` >= 8.
- R4: With `begin_sel` = 0, the request is visible in the same cycle as the trigger strobe.
- R5: A forced request (`tag_sel` = 0) holds `force_brk` high until the cycle in which `insn_bnd` is 1, including that cycle. It is low from the next cycle on.
- R6: A tagged request (`tag_sel` = 1) never drives `force_brk`. It sets `fetch_tag` on the first accepted fetch, in the trigger cycle or later. `tag_brk` pulses in the cycle in which `exec_vld` pops that tagged entry from the queue head.
- R7: In `trig_mode` 0, only A triggers. In `trig_mode` 1, A or B triggers.
- R8: In `trig_mode` 2, A, B or C triggers. In `trig_mode` 3, only C triggers.
- R9: Only one request is issued per run. Triggers in DONE are ignored until `arm` is pulsed.
- R10: `cof_flush` empties the queue, so a tagged entry flushed before reaching the head never produces `tag_brk`.
- R11: The queue is first-in first-out. `exec_op` shows the opcode at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_en | input | 1 | Debug enable |
| brk_en | input | 1 | Breakpoint request enable |
| begin_sel | input | 1 | 1 = begin-trigger (wait for FIFO fill), 0 = end-trigger |
| tag_sel | input | 1 | 1 = tagged request, 0 = forced request |
| trig_mode | input | 2 | 0 A, 1 A or B, 2 A or B or C, 3 C |
| arm | input | 1 | Starts a new run from IDLE or DONE |
| cmp_a | input | 1 | Comparator A match strobe |
| cmp_b | input | 1 | Comparator B match strobe |
| cmp_c | input | 1 | Comparator C match strobe |
| fifo_cnt | input | 4 | Trace FIFO occupancy in words |
| insn_bnd | input | 1 | Instruction boundary strobe |
| fetch_vld | input | 1 | Opcode fetch into the queue |
| fetch_op | input | 8 | Fetched opcode |
| exec_vld | input | 1 | Head opcode executes (queue pop) |
| cof_flush | input | 1 | Change of flow, flushes the queue |
| force_brk | output | 1 | Forced breakpoint request |
| fetch_tag | output | 1 | Tag bit attached to the accepted fetch |
| exec_op | output | 8 | Opcode at the queue head |
| tag_brk | output | 1 | Tagged break at execution of the head |

## Verification
A wrong run state shows at the ports within one cycle of the next strobe that the state decides. A run left in FORCE keeps `force_brk` high after a boundary. A run that wrongly sits in DONE swallows a trigger that should have raised a request. A lost or misplaced tag bit shows only later, when the tagged opcode reaches the head and `tag_brk` appears on the wrong pop or not at all. The bench therefore executes queued entries after each tagging and compares the head opcode too.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FILL,
        ST_FORCE,
        ST_TAGWAIT,
        ST_DONE
    } run_st_e;

    typedef enum logic [1:0] {
        TM_A   = 2'd0,
        TM_AB  = 2'd1,
        TM_ABC = 2'd2,
        TM_C   = 2'd3
    } trig_mode_e;

endpackage

// File: rtl/dbg_trig_sel.sv
module dbg_trig_sel
    import dbg_brk_pkg::*;
(
    input  logic [1:0] trig_mode,
    input  logic       cmp_a,
    input  logic       cmp_b,
    input  logic       cmp_c,
    output logic       hit
);

    always_comb begin
        hit = 1'b0;
        unique case (trig_mode_e'(trig_mode))
            TM_A:    hit = cmp_a;
            TM_AB:   hit = cmp_a | cmp_b;
            TM_ABC:  hit = cmp_a | cmp_b | cmp_c;
            TM_C:    hit = cmp_c;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbg_brk_fsm.sv
module dbg_brk_fsm
    import dbg_brk_pkg::*;
#(
    parameter int FILL_LVL = 8,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_en,
    input  logic             brk_en,
    input  logic             begin_sel,
    input  logic             tag_sel,
    input  logic             arm,
    input  logic             hit,
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic             insn_bnd,
    input  logic             fetch_acc,
    output logic             force_req,
    output logic             tag_req
);

    run_st_e st_q, st_d;
    logic    fill_ok;
    logic    issue;
    run_st_e issue_dest;

    assign fill_ok = (fifo_cnt >= CNT_W'(FILL_LVL));

    // Request leaves the run in this cycle.
    assign issue = brk_en &&
                   (((st_q == ST_ARMED) && hit && !begin_sel) ||
                    ((st_q == ST_FILL) && fill_ok));

    // Where an issued request goes: done at once if taken this cycle.
    always_comb begin
        if (tag_sel) begin
            issue_dest = fetch_acc ? ST_DONE : ST_TAGWAIT;
        end else begin
            issue_dest = insn_bnd ? ST_DONE : ST_FORCE;
        end
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (arm) st_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (hit) begin
                    if (!brk_en)        st_d = ST_DONE;
                    else if (begin_sel) st_d = ST_FILL;
                    else                st_d = issue_dest;
                end
            end
            ST_FILL: begin
                if (fill_ok) begin
                    st_d = brk_en ? issue_dest : ST_DONE;
                end
            end
            ST_FORCE: begin
                if (insn_bnd && brk_en) st_d = ST_DONE;
            end
            ST_TAGWAIT: begin
                if (fetch_acc && brk_en) st_d = ST_DONE;
            end
            ST_DONE: begin
                if (arm) st_d = ST_ARMED;
            end
            default: st_d = ST_IDLE;
        endcase
        if (!dbg_en) st_d = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Outputs.
    always_comb begin
        force_req = 1'b0;
        tag_req   = 1'b0;
        if (dbg_en && brk_en) begin
            force_req = (issue && !tag_sel) || (st_q == ST_FORCE);
            tag_req   = (issue &&  tag_sel) || (st_q == ST_TAGWAIT);
        end
    end

endmodule

// File: rtl/dbg_insn_queue.sv
module dbg_insn_queue #(
    parameter int DEPTH = 4,
    parameter int OP_W  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [OP_W-1:0] push_op,
    input  logic            push_tag,
    input  logic            pop,
    input  logic            flush,
    output logic            full,
    output logic            empty,
    output logic [OP_W-1:0] head_op,
    output logic            head_tag
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [OP_W-1:0]  slot_op  [DEPTH];
    logic             slot_tag [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_op[i]  <= '0;
                slot_tag[i] <= 1'b0;
            end else if (flush) begin
                slot_tag[i] <= 1'b0;
            end else if (do_push && (wr_ptr == PTR_W'(i))) begin
                slot_op[i]  <= push_op;
                slot_tag[i] <= push_tag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head_op  = slot_op[rd_ptr];
    assign head_tag = slot_tag[rd_ptr];

endmodule

// File: rtl/dbg_brk_gen.sv
module dbg_brk_gen #(
    parameter  int FILL_LVL = 8,
    parameter  int Q_DEPTH  = 4,
    parameter  int OP_W     = 8,
    localparam int CNT_W    = $clog2(FILL_LVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_en,
    input  logic             brk_en,
    input  logic             begin_sel,
    input  logic             tag_sel,
    input  logic [1:0]       trig_mode,
    input  logic             arm,
    input  logic             cmp_a,
    input  logic             cmp_b,
    input  logic             cmp_c,
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic             insn_bnd,
    input  logic             fetch_vld,
    input  logic [OP_W-1:0]  fetch_op,
    input  logic             exec_vld,
    input  logic             cof_flush,
    output logic             force_brk,
    output logic             fetch_tag,
    output logic [OP_W-1:0]  exec_op,
    output logic             tag_brk
);

    logic hit;
    logic tag_req;
    logic q_full, q_empty, q_head_tag;
    logic fetch_acc;

    assign fetch_acc = fetch_vld && !q_full && !cof_flush;
    assign fetch_tag = tag_req && fetch_acc;

    dbg_trig_sel u_sel (
        .trig_mode (trig_mode),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .cmp_c     (cmp_c),
        .hit       (hit)
    );

    dbg_brk_fsm #(
        .FILL_LVL (FILL_LVL),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbg_en    (dbg_en),
        .brk_en    (brk_en),
        .begin_sel (begin_sel),
        .tag_sel   (tag_sel),
        .arm       (arm),
        .hit       (hit),
        .fifo_cnt  (fifo_cnt),
        .insn_bnd  (insn_bnd),
        .fetch_acc (fetch_acc),
        .force_req (force_brk),
        .tag_req   (tag_req)
    );

    dbg_insn_queue #(
        .DEPTH (Q_DEPTH),
        .OP_W  (OP_W)
    ) u_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fetch_vld),
        .push_op  (fetch_op),
        .push_tag (fetch_tag),
        .pop      (exec_vld),
        .flush    (cof_flush),
        .full     (q_full),
        .empty    (q_empty),
        .head_op  (exec_op),
        .head_tag (q_head_tag)
    );

    assign tag_brk = dbg_en && exec_vld && !q_empty && q_head_tag;

endmodule

// File: rtl/dbg_brk_chk.sv
module dbg_brk_chk (
    input logic clk,
    input logic rst_n,
    input logic dbg_en,
    input logic brk_en,
    input logic insn_bnd,
    input logic fetch_vld,
    input logic exec_vld,
    input logic cof_flush,
    input logic force_brk,
    input logic fetch_tag,
    input logic tag_brk
);

    // R1
    dbg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_en |-> (!force_brk && !fetch_tag && !tag_brk));

    // R2
    brk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_en |-> (!force_brk && !fetch_tag));

    // R5
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_brk && !insn_bnd) |=> (force_brk || !dbg_en || !brk_en));

    // R9
    force_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_brk && insn_bnd) |=> !force_brk);

    // R6
    tag_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_brk |-> exec_vld);

    // R6
    tag_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_tag |-> (fetch_vld && !cof_flush));

    // R10
    flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cof_flush |=> !tag_brk);

endmodule

bind dbg_brk_gen dbg_brk_chk u_chk (.*);

// File: tb/tb_dbg_brk_gen.sv
`timescale 1ns/1ps
module tb_dbg_brk_gen;

    localparam int S_A   = 1;
    localparam int S_B   = 2;
    localparam int S_C   = 4;
    localparam int S_ARM = 8;
    localparam int S_BND = 16;
    localparam int S_FV  = 32;
    localparam int S_EX  = 64;
    localparam int S_FL  = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dbg_en = 1'b0, brk_en = 1'b0, begin_sel = 1'b0, tag_sel = 1'b0;
    logic [1:0] trig_mode = 2'd0;
    logic       arm = 1'b0, cmp_a = 1'b0, cmp_b = 1'b0, cmp_c = 1'b0;
    logic [3:0] fifo_cnt = 4'd0;
    logic       insn_bnd = 1'b0, fetch_vld = 1'b0, exec_vld = 1'b0, cof_flush = 1'b0;
    logic [7:0] fetch_op = 8'd0;
    logic       force_brk, fetch_tag, tag_brk;
    logic [7:0] exec_op;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    typedef struct {
        logic       f;
        logic       t;
        logic       b;
        bit         chk_op;
        logic [7:0] op;
        string      rq;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    dbg_brk_gen dut (
        .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .brk_en(brk_en),
        .begin_sel(begin_sel), .tag_sel(tag_sel), .trig_mode(trig_mode),
        .arm(arm), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
        .fifo_cnt(fifo_cnt), .insn_bnd(insn_bnd), .fetch_vld(fetch_vld),
        .fetch_op(fetch_op), .exec_vld(exec_vld), .cof_flush(cof_flush),
        .force_brk(force_brk), .fetch_tag(fetch_tag), .exec_op(exec_op),
        .tag_brk(tag_brk)
    );

    // Monitor: compares one expected item per cycle, away from the edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb.pop_front();
            bad = (force_brk !== e.f) || (fetch_tag !== e.t) || (tag_brk !== e.b) ||
                  (e.chk_op && (exec_op !== e.op));
            compared++;
            if (bad) begin
                mismatched++;
                $display("FAIL %s: got f=%b t=%b b=%b op=%h, expected f=%b t=%b b=%b op=%h",
                         e.rq, force_brk, fetch_tag, tag_brk, exec_op,
                         e.f, e.t, e.b, e.op);
            end
        end
    end

    // Driver: applies one cycle of strobes and queues the expectation.
    task automatic drive(input int s, input logic [7:0] op,
                         input logic ef, input logic et, input logic eb,
                         input bit co, input logic [7:0] eop, input string rq);
        exp_t e;
        cmp_a     = (s & S_A)   != 0;
        cmp_b     = (s & S_B)   != 0;
        cmp_c     = (s & S_C)   != 0;
        arm       = (s & S_ARM) != 0;
        insn_bnd  = (s & S_BND) != 0;
        fetch_vld = (s & S_FV)  != 0;
        exec_vld  = (s & S_EX)  != 0;
        cof_flush = (s & S_FL)  != 0;
        fetch_op  = op;
        e.f = ef; e.t = et; e.b = eb; e.chk_op = co; e.op = eop; e.rq = rq;
        sb.push_back(e);
        @(posedge clk);
        #1;
    endtask

    task automatic c(input int s, input logic ef, input string rq);
        drive(s, 8'h00, ef, 1'b0, 1'b0, 1'b0, 8'h00, rq);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compared++;
        if (force_brk !== 1'b0 || fetch_tag !== 1'b0 || tag_brk !== 1'b0) begin
            mismatched++;
            $display("FAIL reset: got f=%b t=%b b=%b, expected 0 0 0",
                     force_brk, fetch_tag, tag_brk);
        end
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: debug disabled blocks everything
        brk_en = 1'b1;
        c(S_ARM, 1'b0, "R1");
        c(S_A,   1'b0, "R1");
        dbg_en = 1'b1;
        c(S_ARM, 1'b0, "R1");
        c(S_A,   1'b1, "R4");
        dbg_en = 1'b0;
        c(0,     1'b0, "R1");
        dbg_en = 1'b1;
        c(0,     1'b0, "R1");

        // R2: breakpoint enable low
        brk_en = 1'b0;
        c(S_ARM, 1'b0, "R2");
        c(S_A,   1'b0, "R2");
        brk_en = 1'b1;
        c(S_A,   1'b0, "R2");

        // R4, R5, R9: end-trigger forced request
        c(S_ARM,       1'b0, "R9");
        c(S_A,         1'b1, "R4");
        c(0,           1'b1, "R5");
        c(0,           1'b1, "R5");
        c(S_BND,       1'b1, "R5");
        c(0,           1'b0, "R5");
        c(S_A,         1'b0, "R9");
        c(S_ARM,       1'b0, "R9");
        c(S_A | S_BND, 1'b1, "R9");
        c(0,           1'b0, "R9");

        // R7, R8: trigger modes
        trig_mode = 2'd0;
        c(S_ARM,       1'b0, "R7");
        c(S_B,         1'b0, "R7");
        c(S_C,         1'b0, "R7");
        trig_mode = 2'd1;
        c(S_B | S_BND, 1'b1, "R7");
        trig_mode = 2'd3;
        c(S_ARM,       1'b0, "R8");
        c(S_A | S_B,   1'b0, "R8");
        c(S_C | S_BND, 1'b1, "R8");
        trig_mode = 2'd2;
        c(S_ARM,       1'b0, "R8");
        c(S_C,         1'b1, "R8");
        c(S_BND,       1'b1, "R8");
        trig_mode = 2'd0;

        // R3: begin-trigger waits for eight words
        begin_sel = 1'b1;
        fifo_cnt  = 4'd3;
        c(S_ARM, 1'b0, "R3");
        c(S_A,   1'b0, "R3");
        fifo_cnt = 4'd7;
        c(0,     1'b0, "R3");
        fifo_cnt = 4'd8;
        c(0,     1'b1, "R3");
        fifo_cnt = 4'd2;
        c(S_BND, 1'b1, "R3");
        c(0,     1'b0, "R3");
        begin_sel = 1'b0;
        fifo_cnt  = 4'd0;

        // R6, R11: tagged request through the queue
        tag_sel = 1'b1;
        c(S_FL, 1'b0, "R6");
        drive(S_ARM | S_FV, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R6");
        drive(S_A | S_FV,   8'h11, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R6");
        drive(S_EX,         8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h10, "R11");
        drive(S_EX,         8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h11, "R6");
        drive(S_EX,         8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R6");

        // R10: flushed tag never breaks
        c(S_ARM, 1'b0, "R10");
        c(S_A,   1'b0, "R6");
        drive(S_FV, 8'h20, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R6");
        c(S_FL,  1'b0, "R10");
        drive(S_FV, 8'h21, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R10");
        drive(S_EX, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h21, "R10");
        tag_sel = 1'b0;
        c(0, 1'b0, "R9");

        @(negedge clk);
        #1;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got no end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule